// File: doc/BRIEF.md
# Single-Cycle Recovery Sequencer

After a load step on a switching regulator, this block produces the single on/off gate action that puts back the charge the output capacitor lost or gained. It does not compute the interval lengths. It takes an on-time count and an off-time count from outside, plus a correction from the peak-capture logic, and plays them out as exactly one on interval and one off interval on the power-switch control line.

Two events drive it. A start pulse says a deviation has been seen. On that pulse the block latches the direction and pre-sets the switch: on for a voltage dip, off for an overshoot. A later trigger pulse marks the peak or valley and launches the timed pair. For a dip the on interval runs first. For an overshoot the off interval runs first. When the first interval ends, the switch flips and the other interval starts. When the second interval ends, a one-cycle done pulse returns control to the steady-state compensator.

Top module: `recovery_seq`

## Requirements
- R1: During reset and after its release, `sw_o` is 0 and `done_o` is 0.
- R2: From idle, a `start_i` sampled high sets `sw_o` to the value of `dip_i` on that same edge: 1 means a dip and turns the switch on, 0 means an overshoot and turns it off.
- R3: The trigger interval is measured from the edge that samples `trig_i` while armed. `sw_o` flips N1 edges after that edge and not before. N1 is the adjusted on-count for a dip and `off_cnt_i` for an overshoot.
- R4: `done_o` is high N1+N2 edges after the trigger edge. N2 is the count of the other interval. `sw_o` flips exactly once over the whole sequence.
- R5: The adjusted on-count is `on_cnt_i - corr_i` when that difference is positive, and 0 otherwise.
- R6: A zero count skips its interval. For N1=0 the flip happens on the trigger edge itself. For N2=0 `done_o` rises on the same edge as the flip.
- R7: `done_o` is high for exactly one cycle. `sw_o` keeps its final value after done until the next accepted start.
- R8: A `trig_i` pulse while idle has no effect on `sw_o` or `done_o`.
- R9: While a sequence runs, `start_i` and `trig_i` are ignored. Re-arming is possible only after done.
- R10: Both counts, the correction and the direction are taken on the trigger edge. Changes to these inputs during the sequence do not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Deviation detected; arms the block when idle |
| dip_i | input | 1 | Transient direction at start: 1 dip, 0 overshoot |
| trig_i | input | 1 | Peak or valley detected; launches the timed pair |
| on_cnt_i | input | CW | On-interval length in cycles |
| off_cnt_i | input | CW | Off-interval length in cycles |
| corr_i | input | KW | Delay correction subtracted from the on count |
| sw_o | output | 1 | Power-switch control line |
| done_o | output | 1 | One-cycle pulse at sequence end |

## Verification
With both counts at zero, the flip of the switch latch and the done pulse land on the same edge as the trigger. A directed sequence with on count equal to the correction and a zero off count drives exactly that case, including the clamp. The bench then samples that `sw_o` has flipped and `done_o` is high at the first sample after the trigger, and that done is low one cycle later. Random runs also hit one zero-length interval at a time. In those runs the bench checks that the flip still happens exactly once and on the predicted edge.

// File: rtl/rseq_pkg.sv
// Shared types for the recovery sequencer.
package rseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,    // waiting for a start
        ST_ARMED,   // direction latched, waiting for the trigger
        ST_FIRST,   // first interval running
        ST_SECOND   // second interval running
    } rseq_state_e;
endpackage

// File: rtl/rseq_trim.sv
// Subtracts the delay correction from the on count, clamping at zero.
// Assumes KW <= CW.
module rseq_trim #(
    parameter int CW = 8,
    parameter int KW = 4
) (
    input  logic [CW-1:0] on_i,
    input  logic [KW-1:0] corr_i,
    output logic [CW-1:0] adj_o
);
    logic [CW-1:0] corr_ext;

    // widen correction and form the saturating difference
    always_comb begin
        corr_ext = CW'(corr_i);
        adj_o    = (on_i > corr_ext) ? (on_i - corr_ext) : '0;
    end
endmodule

// File: rtl/rseq_timer.sv
// Loadable down counter standing in for one delay line.
// A load of N raises exp_o during the cycle before the N-th edge after
// the load edge. A load of 0 leaves the timer silent.
module rseq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          exp_o
);
    logic [CW-1:0] cnt_q;

    // load or count down towards zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    // last cycle of the interval
    always_comb exp_o = (cnt_q == CW'(1));
endmodule

// File: rtl/rseq_ctrl.sv
// Sequence control: start/trigger handling, direction, switch latch and done.
// Assumes the timers follow the rseq_timer load/expire timing.
module rseq_ctrl
    import rseq_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          dip_i,
    input  logic          trig_i,
    input  logic [CW-1:0] on_adj_i,
    input  logic [CW-1:0] off_i,
    input  logic          exp_on_i,
    input  logic          exp_off_i,
    output logic          load_on_o,
    output logic [CW-1:0] val_on_o,
    output logic          load_off_o,
    output logic [CW-1:0] val_off_o,
    output logic          sw_o,
    output logic          done_o,
    output rseq_state_e   state_o
);
    rseq_state_e   state_q;
    logic          dir_q;
    logic          sw_q;
    logic          done_q;
    logic [CW-1:0] sec_q;

    logic          take_trig;
    logic [CW-1:0] first_val, second_in, second_val;
    logic          exp_first, exp_second;
    logic          first_end, second_end;

    // decode interval ends and timer loads for the current direction
    always_comb begin
        take_trig  = (state_q == ST_ARMED) && trig_i;
        first_val  = dir_q ? on_adj_i : off_i;
        second_in  = dir_q ? off_i : on_adj_i;
        second_val = take_trig ? second_in : sec_q;
        exp_first  = dir_q ? exp_on_i : exp_off_i;
        exp_second = dir_q ? exp_off_i : exp_on_i;
        first_end  = (take_trig && first_val == '0) ||
                     (state_q == ST_FIRST && exp_first);
        second_end = (first_end && second_val == '0) ||
                     (state_q == ST_SECOND && exp_second);
        load_on_o  = dir_q ? take_trig : first_end;
        load_off_o = dir_q ? first_end : take_trig;
        val_on_o   = dir_q ? first_val : second_val;
        val_off_o  = dir_q ? second_val : first_val;
    end

    // state, direction, held second count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
            sec_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_ARMED;
                    dir_q   <= dip_i;
                end
                ST_ARMED: if (take_trig) begin
                    sec_q <= second_in;
                    if (second_end)     state_q <= ST_IDLE;
                    else if (first_end) state_q <= ST_SECOND;
                    else                state_q <= ST_FIRST;
                end
                ST_FIRST: if (first_end)
                    state_q <= second_end ? ST_IDLE : ST_SECOND;
                ST_SECOND: if (second_end)
                    state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // switch latch: preset on start, toggle once at the end of the first interval
    always_ff @(posedge clk) begin
        if (!rst_n)
            sw_q <= 1'b0;
        else if (state_q == ST_IDLE && start_i)
            sw_q <= dip_i;
        else if (first_end)
            sw_q <= ~sw_q;
    end

    // one-cycle completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= second_end;
    end

    assign sw_o    = sw_q;
    assign done_o  = done_q;
    assign state_o = state_q;
endmodule

// File: rtl/recovery_seq.sv
// Top of the recovery sequencer: trims the on count, runs the two interval
// timers and the control/latch logic. Synchronous active-low reset.
module recovery_seq
    import rseq_pkg::*;
#(
    parameter int CW = 8,
    parameter int KW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          dip_i,
    input  logic          trig_i,
    input  logic [CW-1:0] on_cnt_i,
    input  logic [CW-1:0] off_cnt_i,
    input  logic [KW-1:0] corr_i,
    output logic          sw_o,
    output logic          done_o
);
    localparam int NT = 2;   // index 0: on timer, index 1: off timer

    logic [CW-1:0] on_adj;
    logic [NT-1:0] t_load, t_exp;
    logic [CW-1:0] t_val [NT];
    rseq_state_e   state_w;

    rseq_trim #(.CW(CW), .KW(KW)) u_trim (
        .on_i(on_cnt_i), .corr_i(corr_i), .adj_o(on_adj)
    );

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        rseq_timer #(.CW(CW)) u_tmr (
            .clk(clk), .rst_n(rst_n), .load_i(t_load[i]),
            .val_i(t_val[i]), .exp_o(t_exp[i])
        );
    end

    rseq_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dip_i(dip_i),
        .trig_i(trig_i), .on_adj_i(on_adj), .off_i(off_cnt_i),
        .exp_on_i(t_exp[0]), .exp_off_i(t_exp[1]),
        .load_on_o(t_load[0]), .val_on_o(t_val[0]),
        .load_off_o(t_load[1]), .val_off_o(t_val[1]),
        .sw_o(sw_o), .done_o(done_o), .state_o(state_w)
    );
endmodule

// File: rtl/rseq_chk.sv
// Property checker for recovery_seq, attached by bind.
module rseq_chk
    import rseq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        sw_o,
    input logic        done_o,
    input rseq_state_e state
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start_i) |=> $stable(sw_o));

    // R8
    idle_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start_i) |=> (state == ST_IDLE && !done_o));

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state == ST_IDLE));

    // R4
    single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SECOND) |=> $stable(sw_o));
endmodule

bind recovery_seq rseq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .sw_o(sw_o), .done_o(done_o), .state(state_w)
);

// File: tb/sim_recovery_seq.sv
module sim_recovery_seq;
    localparam int CW = 8;
    localparam int KW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, dip_i = 1'b0, trig_i = 1'b0;
    logic [CW-1:0] on_cnt_i = '0, off_cnt_i = '0;
    logic [KW-1:0] corr_i = '0;
    logic          sw_o, done_o;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    bit over = 1'b0;

    recovery_seq #(.CW(CW), .KW(KW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dip_i(dip_i),
        .trig_i(trig_i), .on_cnt_i(on_cnt_i), .off_cnt_i(off_cnt_i),
        .corr_i(corr_i), .sw_o(sw_o), .done_o(done_o)
    );

    always #5 clk = ~clk;

    function automatic int clampsub(int a, int b);
        return (a > b) ? a - b : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one full sequence; optional injection of stray start/trigger/count changes
    task automatic run_seq(bit d, int on, int off, int corr, bit inject);
        int n1, n2, adj;
        string tg;
        adj = clampsub(on, corr);
        n1  = d ? adj : off;
        n2  = d ? off : adj;
        tg  = (n1 == 0 || n2 == 0) ? "R6" : ((on <= corr) ? "R5" : "R3");
        @(negedge clk);
        start_i = 1'b1; dip_i = d;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 sw after start", sw_o, d);
        on_cnt_i = CW'(on); off_cnt_i = CW'(off); corr_i = KW'(corr);
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        for (int c = 0; c <= n1 + n2 + 2; c++) begin
            chk({tg, " sw timing"}, sw_o, (c < n1) ? d : !d);
            chk((c == n1 + n2) ? "R4 done timing" : "R7 done width",
                done_o, (c == n1 + n2) ? 1 : 0);
            if (inject && n1 + n2 >= 2 && c == 0) begin
                // R9 R10: stray pulses and changed inputs mid-sequence
                start_i = 1'b1; trig_i = 1'b1; dip_i = !d;
                on_cnt_i = CW'($urandom_range(0, 20));
                off_cnt_i = CW'($urandom_range(0, 20));
                corr_i = KW'($urandom_range(0, 7));
            end else begin
                start_i = 1'b0; trig_i = 1'b0;
            end
            @(negedge clk);
        end
        chk("R7 sw holds after done", sw_o, !d);
    endtask

    initial begin
        int r;
        r = $urandom(32'd77);
        repeat (3) @(negedge clk);
        chk("R1 sw in reset", sw_o, 0);
        chk("R1 done in reset", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sw after reset", sw_o, 0);
        chk("R1 done after reset", done_o, 0);

        // R8: trigger while idle
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 idle trig sw", sw_o, 0);
        chk("R8 idle trig done", done_o, 0);

        // directed corners
        run_seq(1'b1, 5, 0, 5, 1'b0);   // R5 R6 both intervals zero
        run_seq(1'b0, 0, 0, 0, 1'b0);   // R6
        run_seq(1'b1, 3, 4, 9, 1'b0);   // R5 clamp
        run_seq(1'b0, 6, 0, 2, 1'b0);   // R6 first overshoot interval zero
        run_seq(1'b1, 10, 7, 3, 1'b1);  // R9 R10
        run_seq(1'b0, 9, 5, 1, 1'b1);   // R9 R10

        // R8 after a finished sequence
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 trig after done sw", sw_o, 1);
        chk("R8 trig after done done", done_o, 0);

        for (int k = 0; k < 60; k++)
            run_seq(1'($urandom_range(0, 1)), $urandom_range(0, 20),
                    $urandom_range(0, 20), $urandom_range(0, 7),
                    1'($urandom_range(0, 1)));

        over = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !over) begin
            over = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule